// File: doc/BRIEF.md
# Modulated UART Baud Rate Generator

This block produces the timing strobes for a UART transmitter or receiver from a single reference clock. It has a 16-bit integer prescaler and two fractional modulation settings, so the average bit period can fall between whole numbers of reference cycles. It does not hold the shift registers, framing logic or buffers of the UART.

A mode input chooses one of two timing paths. In direct mode, each bit lasts a whole number of reference cycles. In oversampling mode, each bit is split into sixteen sample periods. The first-stage setting lengthens some of the sample periods within a bit. The second-stage setting lengthens chosen bits within a character. A start pulse from the receiver restarts the sequence at each start edge. The configuration is captured only while the block is disabled.

Top module: `modulated_baud_gen`

## Requirements
- R1: `overSample`=0 selects direct mode, where each bit is counted in reference cycles and no sample ticks occur. `overSample`=1 selects oversampling mode, where each bit is built from 16 sample periods.
- R2: The prescaler value is N = `prescLo` + 256 × `prescHi`.
- R3: In direct mode, a prescaler below 3 is used as 3, so the shortest bit is 3 reference cycles.
- R4: In direct mode, bit b of a character lasts N cycles (after the R3 clamp), plus 1 when second-stage bit b is set. `bitTick` is high on the last cycle of each bit.
- R5: In oversampling mode, sample k (0..15) lasts max(N,1) cycles, plus 1 when first-stage bit k is set. For setting f and a slot count S, position p is set when floor((p+1)·f/S) differs from floor(p·f/S); the first stage uses S=16 and the second stage uses S=8. `sampleTick` is high on the last cycle of each sample.
- R6: In oversampling mode, when second-stage bit b is set, sample 15 of bit b gets one more cycle.
- R7: In oversampling mode, `bitTick` is high together with every 16th `sampleTick`, counted from a restart.
- R8: `midTick` fires once per bit. In direct mode it is high when (P>>1) cycles of a bit of length P have passed. In oversampling mode it is high with the 8th sample tick of each bit.
- R9: A `startPulse` sampled at a clock edge resets the bit index, the sample index and the cycle counter to 0. The bit index wraps from 7 back to 0.
- R10: While `enable` is low, all counters are held at zero and all three outputs stay low.
- R11: The configuration inputs are captured only at edges where `enable` is low. Changes made while `enable` is high have no effect until the block is disabled and enabled again.
- R12: In direct mode, `sampleTick` never goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low clears the counters and captures the configuration |
| startPulse | input | 1 | Restarts the bit and sample sequence |
| prescLo | input | 8 | Low byte of the prescaler |
| prescHi | input | 8 | High byte of the prescaler |
| overSample | input | 1 | Mode select: 0 direct, 1 sixteen-times oversampling |
| firstMod | input | 4 | First-stage modulation setting |
| secondMod | input | 3 | Second-stage modulation setting |
| bitTick | output | 1 | High on the last cycle of each bit |
| sampleTick | output | 1 | High on the last cycle of each sample period |
| midTick | output | 1 | Strobe at the middle of each bit |

## Verification
A wrong bit or sample index shows up at the ports as a bit period that is one cycle too long or too short, at the first bit whose modulation bit differs. That is within one character, and the reference model compares every cycle. A cycle counter that overruns its limit removes a tick outright, which the next expected tick exposes. A configuration copy that updates while enabled changes the next bit length right away. A start pulse that fails to rewind the sequence puts the lengthened bits in the wrong positions within eight bits.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic       clearCnt;     // restart the cycle counter next edge
    logic [1:0] extraCycles;  // modulation cycles added to the running period
  } ctrlStrobe_t;

  // Even spreading of `setting` marks over `slots` positions.
  function automatic logic spreadBit(input int setting, input int pos, input int slots);
    int upper;
    int lower;
    upper = ((pos + 1) * setting) / slots;
    lower = (pos * setting) / slots;
    return upper != lower;
  endfunction

endpackage

// File: rtl/baudgen_datapath.sv
module baudgen_datapath
  import baudgen_pkg::*;
#(
  parameter int PRESC_W  = 16,
  parameter int FIRST_W  = 4,
  parameter int SECOND_W = 3,
  parameter int LF_MIN   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [7:0]          prescLo,
  input  logic [PRESC_W-9:0]  prescHi,
  input  logic                overSample,
  input  logic [FIRST_W-1:0]  firstMod,
  input  logic [SECOND_W-1:0] secondMod,
  input  ctrlStrobe_t         strobe,
  output logic                cfgOs,
  output logic [FIRST_W-1:0]  cfgFirst,
  output logic [SECOND_W-1:0] cfgSecond,
  output logic                atEnd,
  output logic                atHalf
);

  localparam int CNT_W = PRESC_W + 2;

  logic [PRESC_W-1:0] cfgPresc;
  logic [CNT_W-1:0]   cycleCnt;
  logic [CNT_W-1:0]   basePeriod;
  logic [CNT_W-1:0]   periodLen;
  logic [CNT_W-1:0]   periodLast;
  logic [CNT_W-1:0]   halfLast;

  // Configuration copy, loaded only while the block is disabled.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgPresc  <= '0;
      cfgOs     <= 1'b0;
      cfgFirst  <= '0;
      cfgSecond <= '0;
    end else if (!enable) begin
      cfgPresc  <= {prescHi, prescLo};
      cfgOs     <= overSample;
      cfgFirst  <= firstMod;
      cfgSecond <= secondMod;
    end
  end

  // Effective base period for the selected path.
  always_comb begin
    if (cfgOs) begin
      basePeriod = (cfgPresc == '0) ? CNT_W'(1) : CNT_W'(cfgPresc);
    end else begin
      basePeriod = (cfgPresc < PRESC_W'(LF_MIN)) ? CNT_W'(LF_MIN) : CNT_W'(cfgPresc);
    end
    periodLen  = basePeriod + CNT_W'(strobe.extraCycles);
    periodLast = periodLen - CNT_W'(1);
    halfLast   = (periodLen >> 1) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleCnt <= '0;
    end else if (strobe.clearCnt) begin
      cycleCnt <= '0;
    end else begin
      cycleCnt <= cycleCnt + CNT_W'(1);
    end
  end

  assign atEnd  = (cycleCnt == periodLast);
  assign atHalf = (cycleCnt == halfLast);

  // R4: the counter never runs past the end of the current period
  assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> (cycleCnt <= periodLast));

  // R11: the configuration copy does not move across an enabled edge
  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> ($stable(cfgPresc) && $stable(cfgOs) && $stable(cfgFirst) && $stable(cfgSecond)));

endmodule

// File: rtl/baudgen_control.sv
module baudgen_control
  import baudgen_pkg::*;
#(
  parameter int SAMPLES   = 16,
  parameter int CHAR_BITS = 8,
  parameter int FIRST_W   = 4,
  parameter int SECOND_W  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                startPulse,
  input  logic                cfgOs,
  input  logic [FIRST_W-1:0]  cfgFirst,
  input  logic [SECOND_W-1:0] cfgSecond,
  input  logic                atEnd,
  input  logic                atHalf,
  output ctrlStrobe_t         strobe,
  output logic                bitTick,
  output logic                sampleTick,
  output logic                midTick
);

  localparam int SAMP_W     = $clog2(SAMPLES);
  localparam int BIT_W      = $clog2(CHAR_BITS);
  localparam int MID_SAMPLE = SAMPLES / 2 - 1;

  logic [SAMPLES-1:0]   firstPat;
  logic [CHAR_BITS-1:0] secondPat;
  logic [SAMP_W-1:0]    sampleIdx;
  logic [BIT_W-1:0]     bitIdx;
  logic                 lastSample;
  logic                 bitDone;

  // Modulation patterns built from the captured settings.
  for (genvar k = 0; k < SAMPLES; k++) begin : gFirstPat
    assign firstPat[k] = spreadBit(int'(cfgFirst), k, SAMPLES);
  end
  for (genvar b = 0; b < CHAR_BITS; b++) begin : gSecondPat
    assign secondPat[b] = spreadBit(int'(cfgSecond), b, CHAR_BITS);
  end

  assign lastSample = (sampleIdx == SAMP_W'(SAMPLES - 1));
  assign bitDone    = atEnd && (!cfgOs || lastSample);

  always_comb begin
    if (cfgOs) begin
      strobe.extraCycles = {1'b0, firstPat[sampleIdx]}
                         + {1'b0, lastSample & secondPat[bitIdx]};
    end else begin
      strobe.extraCycles = {1'b0, secondPat[bitIdx]};
    end
    strobe.clearCnt = !enable || startPulse || atEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleIdx <= '0;
      bitIdx    <= '0;
    end else if (!enable || startPulse) begin
      sampleIdx <= '0;
      bitIdx    <= '0;
    end else begin
      if (cfgOs && atEnd) begin
        sampleIdx <= lastSample ? '0 : sampleIdx + SAMP_W'(1);
      end
      if (bitDone) begin
        bitIdx <= (bitIdx == BIT_W'(CHAR_BITS - 1)) ? '0 : bitIdx + BIT_W'(1);
      end
    end
  end

  assign sampleTick = enable && cfgOs && atEnd;
  assign bitTick    = enable && bitDone;
  assign midTick    = enable && (cfgOs ? (atEnd && sampleIdx == SAMP_W'(MID_SAMPLE)) : atHalf);

  // R10: nothing leaves the block while disabled
  assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !(bitTick || sampleTick || midTick));

  // R12: the direct path never emits sample ticks
  assert_no_sample_direct_R12: assert property (@(posedge clk) disable iff (!rstN)
    !cfgOs |-> !sampleTick);

  // R7: in oversampling mode a bit ends only on a sample boundary
  assert_bit_on_sample_R7: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && cfgOs) |-> sampleTick);

  // R9: a start pulse rewinds both indices
  assert_start_rewinds_R9: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (bitIdx == '0 && sampleIdx == '0));

  // R8: the mid strobe never coincides with the end of a bit
  assert_mid_apart_R8: assert property (@(posedge clk) disable iff (!rstN)
    midTick |-> !bitTick);

endmodule

// File: rtl/modulated_baud_gen.sv
module modulated_baud_gen
  import baudgen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       startPulse,
  input  logic [7:0] prescLo,
  input  logic [7:0] prescHi,
  input  logic       overSample,
  input  logic [3:0] firstMod,
  input  logic [2:0] secondMod,
  output logic       bitTick,
  output logic       sampleTick,
  output logic       midTick
);

  localparam int PRESC_W   = 16;
  localparam int FIRST_W   = 4;
  localparam int SECOND_W  = 3;
  localparam int SAMPLES   = 1 << FIRST_W;
  localparam int CHAR_BITS = 1 << SECOND_W;

  ctrlStrobe_t         strobe;
  logic                cfgOs;
  logic [FIRST_W-1:0]  cfgFirst;
  logic [SECOND_W-1:0] cfgSecond;
  logic                atEnd;
  logic                atHalf;

  baudgen_datapath #(
    .PRESC_W (PRESC_W),
    .FIRST_W (FIRST_W),
    .SECOND_W(SECOND_W),
    .LF_MIN  (3)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .prescLo   (prescLo),
    .prescHi   (prescHi),
    .overSample(overSample),
    .firstMod  (firstMod),
    .secondMod (secondMod),
    .strobe    (strobe),
    .cfgOs     (cfgOs),
    .cfgFirst  (cfgFirst),
    .cfgSecond (cfgSecond),
    .atEnd     (atEnd),
    .atHalf    (atHalf)
  );

  baudgen_control #(
    .SAMPLES  (SAMPLES),
    .CHAR_BITS(CHAR_BITS),
    .FIRST_W  (FIRST_W),
    .SECOND_W (SECOND_W)
  ) uControl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .startPulse(startPulse),
    .cfgOs     (cfgOs),
    .cfgFirst  (cfgFirst),
    .cfgSecond (cfgSecond),
    .atEnd     (atEnd),
    .atHalf    (atHalf),
    .strobe    (strobe),
    .bitTick   (bitTick),
    .sampleTick(sampleTick),
    .midTick   (midTick)
  );

endmodule

// File: tb/tb_modulated_baud_gen.sv
module tb_modulated_baud_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       startPulse = 1'b0;
  logic [7:0] prescLo = '0;
  logic [7:0] prescHi = '0;
  logic       overSample = 1'b0;
  logic [3:0] firstMod = '0;
  logic [2:0] secondMod = '0;
  logic       bitTick;
  logic       sampleTick;
  logic       midTick;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  modulated_baud_gen dut (
    .clk(clk), .rstN(rstN), .enable(enable), .startPulse(startPulse),
    .prescLo(prescLo), .prescHi(prescHi), .overSample(overSample),
    .firstMod(firstMod), .secondMod(secondMod),
    .bitTick(bitTick), .sampleTick(sampleTick), .midTick(midTick)
  );

  // ---------------- behavioural reference model ----------------
  int mCnt = 0, mSamp = 0, mBit = 0;
  int mPresc = 0, mFirst = 0, mSec = 0;
  bit mOs = 1'b0;

  function automatic int spread(int setting, int pos, int slots);
    return (((pos + 1) * setting) / slots != (pos * setting) / slots) ? 1 : 0;
  endfunction

  function automatic int curPeriod();
    int base;
    int extra;
    if (mOs) begin
      base  = (mPresc == 0) ? 1 : mPresc;
      extra = spread(mFirst, mSamp, 16);
      if (mSamp == 15) extra += spread(mSec, mBit, 8);
    end else begin
      base  = (mPresc < 3) ? 3 : mPresc;
      extra = spread(mSec, mBit, 8);
    end
    return base + extra;
  endfunction

  always @(posedge clk) begin
    int p;
    bit endNow;
    p = curPeriod();
    endNow = (mCnt == p - 1);
    if (!rstN) begin
      mCnt = 0; mSamp = 0; mBit = 0;
      mPresc = 0; mOs = 0; mFirst = 0; mSec = 0;
    end else begin
      if (!enable || startPulse) begin
        mCnt = 0; mSamp = 0; mBit = 0;
      end else begin
        bit bitEnd;
        bitEnd = endNow && (!mOs || mSamp == 15);
        mCnt = endNow ? 0 : mCnt + 1;
        if (endNow && mOs) mSamp = (mSamp == 15) ? 0 : mSamp + 1;
        if (bitEnd) mBit = (mBit + 1) % 8;
      end
      if (!enable) begin
        mPresc = prescLo + 256 * prescHi;
        mOs = overSample; mFirst = firstMod; mSec = secondMod;
      end
    end
  end

  task automatic check(int got, int exp, string tag);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, got, exp);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      int p;
      bit eEnd, eHalf, eBit, eSamp, eMid;
      p = curPeriod();
      eEnd  = (mCnt == p - 1);
      eHalf = (mCnt == p / 2 - 1);
      eBit  = enable && eEnd && (!mOs || mSamp == 15);
      eSamp = enable && mOs && eEnd;
      eMid  = enable && (mOs ? (eEnd && mSamp == 7) : eHalf);
      check(int'(bitTick),    int'(eBit),  !enable ? "R10 bitTick" : (mOs ? "R7 bitTick" : "R4 bitTick"));
      check(int'(sampleTick), int'(eSamp), !enable ? "R10 sampleTick" : (mOs ? "R5 sampleTick" : "R12 sampleTick"));
      check(int'(midTick),    int'(eMid),  !enable ? "R10 midTick" : "R8 midTick");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic stepCycle();
    @(posedge clk); #2;
  endtask

  task automatic configure(bit os, int presc, int f, int s);
    enable = 1'b0;
    stepCycle();
    overSample = os; prescLo = presc[7:0]; prescHi = presc[15:8];
    firstMod = f[3:0]; secondMod = s[2:0];
    stepCycle();
    enable = 1'b1;
    stepCycle();
  endtask

  task automatic pulseStart();
    startPulse = 1'b1;
    @(posedge clk); #2;
    startPulse = 1'b0;
  endtask

  task automatic cyclesToBit(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!bitTick);
  endtask

  task automatic cyclesToMid(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!midTick);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // ---------------- directed scenarios ----------------
  initial begin
    int n;
    repeat (3) @(posedge clk);
    #2;
    @(negedge clk);
    // R10: reset state is silent
    check(int'(bitTick | sampleTick | midTick), 0, "R10 reset");
    rstN = 1'b1;
    stepCycle();

    // R1 R2: direct mode, prescaler 0x0105 = 261 cycles per bit
    configure(1'b0, 261, 0, 0);
    pulseStart();
    cyclesToBit(n); check(n, 261, "R2 first bit");
    cyclesToBit(n); check(n, 261, "R1 direct bit");

    // R3: prescaler 1 clamps to 3
    configure(1'b0, 1, 0, 0);
    pulseStart();
    cyclesToBit(n); check(n, 3, "R3 clamp");
    cyclesToBit(n); check(n, 3, "R3 clamp repeat");

    // R4 R9: second stage 4 lengthens odd bits; wrap after 8
    configure(1'b0, 10, 0, 4);
    pulseStart();
    cyclesToBit(n); check(n, 10, "R9 bit0 after start");
    for (int i = 1; i <= 9; i++) begin
      cyclesToBit(n); check(n, 10 + (i % 2), "R9 wrap sequence");
    end
    // R8: mid strobe at half of a 10-cycle bit
    pulseStart();
    cyclesToMid(n); check(n, 5, "R8 direct mid");

    // R11: change while enabled has no effect
    prescLo = 8'd50; secondMod = 3'd0;
    pulseStart();
    cyclesToBit(n); check(n, 10, "R11 ignored bit0");
    cyclesToBit(n); check(n, 11, "R11 ignored bit1");
    enable = 1'b0; stepCycle(); stepCycle();
    enable = 1'b1; stepCycle();
    pulseStart();
    cyclesToBit(n); check(n, 50, "R11 applied after re-enable");

    // R7 R1: oversampling, prescaler 2, no modulation
    configure(1'b1, 2, 0, 0);
    pulseStart();
    cyclesToBit(n); check(n, 32, "R7 sixteen samples");
    cyclesToMid(n); check(n, 16, "R8 oversample mid");

    // R5 R6: first stage 5, second stage 7 (bit0 clear, bits1..7 set)
    configure(1'b1, 3, 5, 7);
    pulseStart();
    cyclesToBit(n); check(n, 53, "R5 first-stage bit");
    cyclesToBit(n); check(n, 54, "R6 second-stage bit");
    for (int i = 2; i < 10; i++) begin
      cyclesToBit(n); check(n, 53 + spread(7, i % 8, 8), "R6 pattern");
    end

    // R5: prescaler 0 in oversampling acts as 1
    configure(1'b1, 0, 0, 0);
    pulseStart();
    cyclesToBit(n); check(n, 16, "R5 zero prescaler");

    // R12: long direct run is watched by the model for sample ticks
    configure(1'b0, 4, 0, 3);
    repeat (200) @(posedge clk);
    #2;
    enable = 1'b0;
    repeat (20) @(posedge clk);
    #2;

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule